// File: doc/BRIEF.md
# Configurable Tag-Capable SRAM Mat

This block is one 1024-entry by 64-bit storage mat. A single request port carries an external 4-bit opcode, a 10-bit word index, 64 bits of data, a per-byte enable and a 4-bit control value. A 16-entry translation table turns the external opcode into an internal operation and a metadata action. Software loads this table through a small configuration port. The internal operations are plain load, store, tag compare, exchange (read-modify-write), compare-then-store, and two flash clears. Every word also carries a valid flag and a 4-bit control field, which suits the mat to holding cache tags along with their state bits.

Stores are not written into the array in the cycle they arrive. Each store waits one cycle in a single-entry write buffer and drains on the next edge. Reads, compares and exchanges see the buffered bytes through forwarding. Metadata updates take effect at the request edge. A compare reports a hit when the word is valid and every enabled byte equals the supplied data. A compare-then-store commits its data and its metadata action only on a hit.

Top module: `tagmat_top`

## Requirements
- R1: After reset, rsp_valid and rsp_hit are 0, every valid flag and control field is 0, and the table maps external opcodes as follows: 1 to load, 2 to store with metadata set, 3 to compare, 4 to exchange, 5 to compare-then-store with metadata set, 6 to clear valid flags, 7 to clear all metadata, and every other code to no-operation. All actions not listed are keep.
- R2: When cfg_we is high, entry cfg_idx is loaded with cfg_data. Bits 4:2 hold the internal operation (0 nop, 1 load, 2 store, 3 compare, 4 exchange, 5 compare-then-store, 6 clear valid, 7 clear all). Bits 1:0 hold the metadata action (0 keep, 1 set valid and load control from req_ctl, 2 clear valid, 3 load control only). Requests in later cycles use the new entry.
- R3: A store replaces byte b (bits 8b+7:8b) of the addressed word only where req_bmask[b] is 1. All other bytes keep their value.
- R4: Load, compare, exchange and compare-then-store raise rsp_valid in the cycle after the request. rsp_rdata holds the enabled bytes of the word, with disabled bytes reading 0, together with the word's valid flag and control field.
- R5: A request issued in the cycle right after a store to the same word sees the stored bytes.
- R6: rsp_hit is 1 one cycle after a compare or compare-then-store exactly when the word's valid flag is 1 and all enabled bytes equal req_wdata. It is 0 after any other cycle.
- R7: Compare-then-store writes its enabled bytes and applies its metadata action only when it hits.
- R8: Exchange returns the word and metadata as they were before the request, then stores the enabled bytes of req_wdata.
- R9: A metadata action applies at the request edge, and the next request sees it. The response carries the values from before the update. Load, store, compare and exchange always apply their action.
- R10: Clear-valid sets every valid flag to 0 and leaves control fields and data unchanged. Clear-all additionally sets every control field to 0.
- R11: A no-operation request, or any cycle with req_valid low, changes no data and no metadata and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load one translation-table entry |
| cfg_idx | input | 4 | External opcode whose entry is loaded |
| cfg_data | input | 5 | Entry value: {operation[2:0], action[1:0]} |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | External opcode |
| req_addr | input | 10 | Word index |
| req_wdata | input | 64 | Store or compare data |
| req_bmask | input | 8 | Per-byte enable |
| req_ctl | input | 4 | Control value for metadata actions |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Enabled bytes of the word, others zero |
| rsp_vbit | output | 1 | Valid flag of the word before update |
| rsp_ctl | output | 4 | Control field of the word before update |
| rsp_hit | output | 1 | Compare result |

## Verification
The bench first runs directed patterns that separate the cases the datapath can confuse. A load right after a store tests forwarding, while a load a few cycles later tests the drained array. Two partial stores in a row to one word check that the buffer and the array merge in the right order. Compares are tried with a matching word, with a mismatch in an enabled byte, with a mismatch only in a disabled byte, and with the word invalid. These tell the mask, data and valid terms of the hit apart. The bench then remaps opcodes and runs a long pseudo-random mix of all operations over a few words. This mix puts flash clears, exchanges and conditional stores back to back against a behavioural model.

// File: rtl/tagmat_pkg.sv
package tagmat_pkg;

    localparam int DW   = 64;
    localparam int NB   = DW / 8;
    localparam int CW   = 4;
    localparam int OPW  = 4;
    localparam int NOPS = 1 << OPW;

    typedef enum logic [2:0] {
        IOP_NOP    = 3'd0,
        IOP_LOAD   = 3'd1,
        IOP_STORE  = 3'd2,
        IOP_CMP    = 3'd3,
        IOP_XCHG   = 3'd4,
        IOP_CMPST  = 3'd5,
        IOP_CLRV   = 3'd6,
        IOP_CLRALL = 3'd7
    } iop_e;

    typedef enum logic [1:0] {
        MACT_KEEP  = 2'd0,
        MACT_SET   = 2'd1,
        MACT_INVAL = 2'd2,
        MACT_CTL   = 2'd3
    } mact_e;

    typedef struct packed {
        iop_e  op;
        mact_e act;
    } dec_entry_t;

    localparam int ENTW = $bits(dec_entry_t);

    function automatic dec_entry_t default_entry(input int idx);
        dec_entry_t e;
        e.act = MACT_KEEP;
        case (idx)
            1:       e.op = IOP_LOAD;
            2:       begin e.op = IOP_STORE; e.act = MACT_SET; end
            3:       e.op = IOP_CMP;
            4:       e.op = IOP_XCHG;
            5:       begin e.op = IOP_CMPST; e.act = MACT_SET; end
            6:       e.op = IOP_CLRV;
            7:       e.op = IOP_CLRALL;
            default: e.op = IOP_NOP;
        endcase
        return e;
    endfunction

    function automatic logic [DW-1:0] expand_mask(input logic [NB-1:0] m);
        logic [DW-1:0] r;
        for (int b = 0; b < NB; b++) begin
            r[b*8 +: 8] = {8{m[b]}};
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_w,
                                                  input logic [DW-1:0] new_w,
                                                  input logic [NB-1:0] m);
        logic [DW-1:0] bm;
        bm = expand_mask(m);
        return (old_w & ~bm) | (new_w & bm);
    endfunction

endpackage

// File: rtl/tagmat_decode.sv
module tagmat_decode
    import tagmat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [OPW-1:0]  cfg_idx,
    input  logic [ENTW-1:0] cfg_data,
    input  logic [OPW-1:0]  req_op,
    output dec_entry_t      dec
);

    dec_entry_t tbl_q [NOPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NOPS; i++) begin
                tbl_q[i] <= default_entry(i);
            end
        end else if (cfg_we) begin
            tbl_q[cfg_idx] <= dec_entry_t'(cfg_data);
        end
    end

    assign dec = tbl_q[req_op];

    // R2: a configuration write lands in the selected entry
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (tbl_q[$past(cfg_idx)] == dec_entry_t'($past(cfg_data))));

endmodule

// File: rtl/tagmat_meta.sv
module tagmat_meta
    import tagmat_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          upd_en,
    input  mact_e         upd_act,
    input  logic [CW-1:0] upd_ctl,
    input  logic          clr_valid,
    input  logic          clr_all,
    output logic          rd_valid,
    output logic [CW-1:0] rd_ctl
);

    logic [DEPTH-1:0] valid_q;
    logic [CW-1:0]    ctl_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ctl_q[i] <= '0;
            end
        end else if (clr_valid || clr_all) begin
            valid_q <= '0;
            if (clr_all) begin
                for (int i = 0; i < DEPTH; i++) begin
                    ctl_q[i] <= '0;
                end
            end
        end else if (upd_en) begin
            case (upd_act)
                MACT_SET: begin
                    valid_q[addr] <= 1'b1;
                    ctl_q[addr]   <= upd_ctl;
                end
                MACT_INVAL: valid_q[addr] <= 1'b0;
                MACT_CTL:   ctl_q[addr]   <= upd_ctl;
                default: ;
            endcase
        end
    end

    assign rd_valid = valid_q[addr];
    assign rd_ctl   = ctl_q[addr];

    // R10: a flash clear empties every valid flag
    p_flash_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_valid || clr_all) |=> (valid_q == '0));

    // R10: a full clear also zeroes the control field of the word addressed
    p_clrall_ctl_r10: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (ctl_q[$past(addr)] == '0));

    // R9: a set action marks the word valid for the following request
    p_set_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_act == MACT_SET && !clr_valid && !clr_all)
            |=> valid_q[$past(addr)]);

endmodule

// File: rtl/tagmat_store.sv
module tagmat_store
    import tagmat_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NB-1:0] wr_mask
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [NB-1:0] mask;
    } wbuf_t;

    wbuf_t         wb_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] arr_word;
    logic          buf_match;

    // Drain the pending entry into the array on every edge it is present
    always_ff @(posedge clk) begin
        if (wb_q.vld) begin
            mem_q[wb_q.addr] <= merge_bytes(mem_q[wb_q.addr], wb_q.data, wb_q.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q.vld <= wr_en;
            if (wr_en) begin
                wb_q.addr <= wr_addr;
                wb_q.data <= wr_data;
                wb_q.mask <= wr_mask;
            end
        end
    end

    assign arr_word  = mem_q[rd_addr];
    assign buf_match = wb_q.vld && (wb_q.addr == rd_addr);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign rd_word[b*8 +: 8] = (buf_match && wb_q.mask[b]) ? wb_q.data[b*8 +: 8]
                                                               : arr_word[b*8 +: 8];
    end

    // R3: a full-word buffered store is in the array one edge later
    p_drain_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_q.vld && wb_q.mask == '1) |=> (mem_q[$past(wb_q.addr)] == $past(wb_q.data)));

    // R5: a read of the buffered word sees its enabled bytes
    p_forward_r5: assert property (@(posedge clk) disable iff (rst)
        (buf_match && wb_q.mask == '1) |-> (rd_word == wb_q.data));

endmodule

// File: rtl/tagmat_top.sv
module tagmat_top
    import tagmat_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [OPW-1:0]  cfg_idx,
    input  logic [ENTW-1:0] cfg_data,
    input  logic            req_valid,
    input  logic [OPW-1:0]  req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [NB-1:0]   req_bmask,
    input  logic [CW-1:0]   req_ctl,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            rsp_vbit,
    output logic [CW-1:0]   rsp_ctl,
    output logic            rsp_hit
);

    dec_entry_t    dec;
    logic [DW-1:0] cur_word;
    logic [DW-1:0] mask_w;
    logic          m_valid;
    logic [CW-1:0] m_ctl;
    logic          hit_now;
    logic          do_store, do_meta, do_rsp, is_cmp, clr_v, clr_a;

    tagmat_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .req_op   (req_op),
        .dec      (dec)
    );

    tagmat_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (req_addr),
        .rd_word (cur_word),
        .wr_en   (do_store),
        .wr_addr (req_addr),
        .wr_data (req_wdata),
        .wr_mask (req_bmask)
    );

    tagmat_meta #(.DEPTH(DEPTH)) u_meta (
        .clk       (clk),
        .rst       (rst),
        .addr      (req_addr),
        .upd_en    (do_meta),
        .upd_act   (dec.act),
        .upd_ctl   (req_ctl),
        .clr_valid (clr_v),
        .clr_all   (clr_a),
        .rd_valid  (m_valid),
        .rd_ctl    (m_ctl)
    );

    assign mask_w  = expand_mask(req_bmask);
    assign hit_now = m_valid && (((cur_word ^ req_wdata) & mask_w) == '0);

    always_comb begin
        do_store = 1'b0;
        do_meta  = 1'b0;
        do_rsp   = 1'b0;
        is_cmp   = 1'b0;
        clr_v    = 1'b0;
        clr_a    = 1'b0;
        if (req_valid) begin
            case (dec.op)
                IOP_LOAD:  begin do_rsp = 1'b1; do_meta = 1'b1; end
                IOP_STORE: begin do_store = 1'b1; do_meta = 1'b1; end
                IOP_CMP:   begin do_rsp = 1'b1; do_meta = 1'b1; is_cmp = 1'b1; end
                IOP_XCHG:  begin do_rsp = 1'b1; do_meta = 1'b1; do_store = 1'b1; end
                IOP_CMPST: begin
                    do_rsp   = 1'b1;
                    is_cmp   = 1'b1;
                    do_store = hit_now;
                    do_meta  = hit_now;
                end
                IOP_CLRV:   clr_v = 1'b1;
                IOP_CLRALL: clr_a = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
            rsp_vbit  <= 1'b0;
            rsp_ctl   <= '0;
        end else begin
            rsp_valid <= do_rsp;
            rsp_hit   <= is_cmp && hit_now;
            if (do_rsp) begin
                rsp_rdata <= cur_word & mask_w;
                rsp_vbit  <= m_valid;
                rsp_ctl   <= m_ctl;
            end
        end
    end

    // R6: a hit is only reported for a valid word in a response cycle
    p_hit_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_valid && rsp_vbit));

    // R4: every response answers a request of the previous cycle
    p_rsp_latency_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R11: an idle cycle produces no response next cycle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit));

endmodule

// File: tb/tagmat_top_bench.sv
module tagmat_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [4:0]  cfg_data;
    logic        req_valid;
    logic [3:0]  req_op;
    logic [9:0]  req_addr;
    logic [63:0] req_wdata;
    logic [7:0]  req_bmask;
    logic [3:0]  req_ctl;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_vbit;
    logic [3:0]  rsp_ctl;
    logic        rsp_hit;

    int compared   = 0;
    int mismatched = 0;

    // behavioural reference state
    logic [63:0] mem_m [1024];
    bit          val_m [1024];
    logic [3:0]  ctl_m [1024];
    logic [4:0]  tbl_m [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    tagmat_top u_tagmat_top (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_bmask(req_bmask), .req_ctl(req_ctl),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_vbit(rsp_vbit),
        .rsp_ctl(rsp_ctl), .rsp_hit(rsp_hit)
    );

    function automatic logic [63:0] bytes_to_bits(input logic [7:0] m);
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++) if (m[b]) r[b*8 +: 8] = 8'hFF;
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply_meta(input logic [1:0] act, input int a, input logic [3:0] c);
        case (act)
            2'd1: begin val_m[a] = 1'b1; ctl_m[a] = c; end
            2'd2: val_m[a] = 1'b0;
            2'd3: ctl_m[a] = c;
            default: ;
        endcase
    endtask

    task automatic do_req(input bit v, input logic [3:0] op, input int a,
                          input logic [63:0] d, input logic [7:0] m,
                          input logic [3:0] c, input string tag);
        logic [2:0]  iop;
        logic [1:0]  act;
        logic [63:0] mk, old;
        bit          e_rv, e_hit, e_v, hitc;
        logic [3:0]  e_c;
        logic [63:0] e_d;
        req_valid = v; req_op = op; req_addr = a[9:0];
        req_wdata = d; req_bmask = m; req_ctl = c;
        iop = tbl_m[op][4:2];
        act = tbl_m[op][1:0];
        mk  = bytes_to_bits(m);
        old = mem_m[a];
        e_rv = 0; e_hit = 0;
        e_d = old & mk; e_v = val_m[a]; e_c = ctl_m[a];
        hitc = val_m[a] && (((old ^ d) & mk) == 64'd0);
        if (v) begin
            case (iop)
                3'd1: begin e_rv = 1; apply_meta(act, a, c); end
                3'd2: begin mem_m[a] = (old & ~mk) | (d & mk); apply_meta(act, a, c); end
                3'd3: begin e_rv = 1; e_hit = hitc; apply_meta(act, a, c); end
                3'd4: begin e_rv = 1; mem_m[a] = (old & ~mk) | (d & mk); apply_meta(act, a, c); end
                3'd5: begin
                    e_rv = 1; e_hit = hitc;
                    if (hitc) begin
                        mem_m[a] = (old & ~mk) | (d & mk);
                        apply_meta(act, a, c);
                    end
                end
                3'd6: for (int i = 0; i < 1024; i++) val_m[i] = 1'b0;
                3'd7: for (int i = 0; i < 1024; i++) begin val_m[i] = 1'b0; ctl_m[i] = 4'd0; end
                default: ;
            endcase
        end
        @(negedge clk);
        chk(tag, "rsp_valid", {63'd0, rsp_valid}, {63'd0, e_rv});
        chk(tag, "rsp_hit", {63'd0, rsp_hit}, {63'd0, e_hit});
        if (e_rv) begin
            chk(tag, "rsp_rdata", rsp_rdata, e_d);
            chk(tag, "rsp_vbit", {63'd0, rsp_vbit}, {63'd0, e_v});
            chk(tag, "rsp_ctl", {60'd0, rsp_ctl}, {60'd0, e_c});
        end
    endtask

    task automatic idle(input string tag);
        do_req(1'b0, 4'd0, 0, 64'd0, 8'd0, 4'd0, tag);
    endtask

    task automatic cfg_write(input logic [3:0] idx, input logic [2:0] iop, input logic [1:0] act);
        cfg_we = 1'b1; cfg_idx = idx; cfg_data = {iop, act};
        idle("R2");
        tbl_m[idx] = {iop, act};
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [63:0] w;
        for (int i = 0; i < 1024; i++) begin mem_m[i] = '0; val_m[i] = 0; ctl_m[i] = '0; end
        for (int i = 0; i < 16; i++) tbl_m[i] = 5'd0;
        tbl_m[1] = {3'd1, 2'd0}; tbl_m[2] = {3'd2, 2'd1}; tbl_m[3] = {3'd3, 2'd0};
        tbl_m[4] = {3'd4, 2'd0}; tbl_m[5] = {3'd5, 2'd1}; tbl_m[6] = {3'd6, 2'd0};
        tbl_m[7] = {3'd7, 2'd0};
        rst = 1'b1; cfg_we = 0; cfg_idx = 0; cfg_data = 0;
        req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0; req_bmask = 0; req_ctl = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset outputs and default decode, empty metadata
        chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "rsp_hit after reset", {63'd0, rsp_hit}, 64'd0);
        do_req(1, 4'd1, 50, 64'd0, 8'h00, 4'd0, "R1");
        // R3 and R5: full stores, each read straight after
        do_req(1, 4'd2, 0, 64'h1122_3344_5566_7788, 8'hFF, 4'd3, "R3");
        do_req(1, 4'd1, 0, 64'd0, 8'hFF, 4'd0, "R5");
        for (int i = 1; i < 8; i++)
            do_req(1, 4'd2, i, {8{i[7:0] + 8'h30}} ^ 64'hA5A5_0F0F_5A5A_F0F0, 8'hFF, i[3:0], "R3");
        do_req(1, 4'd2, 1023, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 4'hE, "R3");
        do_req(1, 4'd2, 100, 64'h0123_4567_89AB_CDEF, 8'hFF, 4'd1, "R3");
        idle("R11");
        do_req(1, 4'd1, 1023, 64'd0, 8'hFF, 4'd0, "R4");
        // R3 partial store, forwarded then drained
        do_req(1, 4'd2, 5, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, 4'd5, "R3");
        do_req(1, 4'd1, 5, 64'd0, 8'hFF, 4'd0, "R5");
        idle("R11"); idle("R11");
        do_req(1, 4'd1, 5, 64'd0, 8'hFF, 4'd0, "R3");
        // R5: two partial stores in a row to one word
        do_req(1, 4'd2, 100, 64'h1111_1111_1111_1111, 8'hA5, 4'd1, "R3");
        do_req(1, 4'd2, 100, 64'h2222_2222_2222_2222, 8'h5A, 4'd1, "R3");
        do_req(1, 4'd1, 100, 64'd0, 8'hFF, 4'd0, "R5");
        do_req(1, 4'd1, 100, 64'd0, 8'h3C, 4'd0, "R4");
        // R6 compare cases
        do_req(1, 4'd3, 5, mem_m[5], 8'hFF, 4'd0, "R6");
        do_req(1, 4'd3, 5, mem_m[5] ^ 64'h0000_0000_0100_0000, 8'hFF, 4'd0, "R6");
        do_req(1, 4'd3, 5, mem_m[5] ^ 64'h0000_0000_0000_0001, 8'hFE, 4'd0, "R6");
        do_req(1, 4'd3, 50, 64'd0, 8'h00, 4'd0, "R6");
        // R2 remap
        cfg_write(4'd1, 3'd0, 2'd0);
        cfg_write(4'd8, 3'd1, 2'd2);
        cfg_write(4'd9, 3'd2, 2'd3);
        cfg_write(4'hA, 3'd2, 2'd0);
        cfg_write(4'hB, 3'd5, 2'd1);
        cfg_write(4'hC, 3'd4, 2'd1);
        cfg_write(4'hD, 3'd3, 2'd3);
        cfg_write(4'hE, 3'd1, 2'd0);
        do_req(1, 4'd1, 5, 64'd0, 8'hFF, 4'd0, "R2");
        // R9 metadata actions
        do_req(1, 4'd8, 5, 64'd0, 8'hFF, 4'd0, "R9");
        do_req(1, 4'hE, 5, 64'd0, 8'hFF, 4'd0, "R9");
        do_req(1, 4'd3, 5, mem_m[5], 8'hFF, 4'd0, "R6");
        do_req(1, 4'd9, 6, 64'h7777_0000_7777_0000, 8'hF0, 4'd9, "R9");
        do_req(1, 4'hE, 6, 64'd0, 8'hFF, 4'd0, "R9");
        do_req(1, 4'hD, 6, 64'd1, 8'h00, 4'hC, "R9");
        do_req(1, 4'hE, 6, 64'd0, 8'hFF, 4'd0, "R9");
        // R7 conditional store: hit then miss
        do_req(1, 4'hB, 7, mem_m[7], 8'hF0, 4'hA, "R7");
        do_req(1, 4'hE, 7, 64'd0, 8'hFF, 4'd0, "R7");
        do_req(1, 4'hB, 5, mem_m[5], 8'hFF, 4'h2, "R7");
        do_req(1, 4'hE, 5, 64'd0, 8'hFF, 4'd0, "R7");
        do_req(1, 4'hB, 7, ~mem_m[7], 8'h01, 4'h4, "R7");
        do_req(1, 4'hE, 7, 64'd0, 8'hFF, 4'd0, "R7");
        // R8 exchange
        do_req(1, 4'd4, 2, 64'hABCD_ABCD_ABCD_ABCD, 8'hC3, 4'd0, "R8");
        do_req(1, 4'hE, 2, 64'd0, 8'hFF, 4'd0, "R8");
        do_req(1, 4'hC, 5, 64'h5555_5555_5555_5555, 8'hFF, 4'h6, "R8");
        do_req(1, 4'hE, 5, 64'd0, 8'hFF, 4'd0, "R8");
        // R10 flash clears
        do_req(1, 4'd6, 0, 64'd0, 8'h00, 4'd0, "R10");
        for (int i = 0; i < 8; i++) do_req(1, 4'hE, i, 64'd0, 8'hFF, 4'd0, "R10");
        do_req(1, 4'd2, 3, 64'h3333_3333_3333_3333, 8'hFF, 4'hB, "R10");
        do_req(1, 4'd7, 0, 64'd0, 8'h00, 4'd0, "R10");
        for (int i = 0; i < 8; i++) do_req(1, 4'hE, i, 64'd0, 8'hFF, 4'd0, "R10");
        do_req(1, 4'hE, 1023, 64'd0, 8'hFF, 4'd0, "R10");
        // R11 ignored requests
        do_req(0, 4'd2, 3, 64'hFFFF_0000_FFFF_0000, 8'hFF, 4'hF, "R11");
        do_req(1, 4'd0, 3, 64'hFFFF_0000_FFFF_0000, 8'hFF, 4'hF, "R11");
        do_req(1, 4'hE, 3, 64'd0, 8'hFF, 4'd0, "R11");
        // mixed traffic over a few words
        for (int n = 0; n < 400; n++) begin
            int a;
            logic [3:0] op;
            a  = $urandom_range(0, 7);
            op = 4'($urandom_range(0, 15));
            if (op == 4'd6 || op == 4'd7) op = ($urandom_range(0, 3) == 0) ? op : 4'hE;
            w  = ($urandom_range(0, 1) == 1) ? mem_m[a] : {$urandom, $urandom};
            do_req($urandom_range(0, 9) != 0, op, a, w, 8'($urandom), 4'($urandom), "R3");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule